// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block holds the 16-bit management registers of an Ethernet transceiver. They are reached through a 5-bit register number over a plain synchronous port: one address, one write-data bus, a write strobe, a read strobe and a registered read-data bus. Each register number has its own access rule. Some registers store what is written. Some return fixed or configured values and ignore writes. Some always read as zero. Numbers outside the map read as zero and ignore writes.

A link-up input feeds two bits. The first is a live link bit in the specific-status register. The second is a latched-low link bit in the basic status register. The latched bit clears as soon as the link drops. It sets again only after software has read the status register while the link is up. The first identifier is a build-time parameter and the second comes from a configuration input.

The port has no back-pressure. The block takes a strobe in every cycle, so there is no ready signal, and a read strobe always yields data one clock later. Auto-negotiation, interrupts, counters and a real soft reset are not modelled.

Top module: `phymgmt_regs`

## Requirements
- R1: After reset, these reads return the following values: register 0 (control) 0x1140, register 1 (status) 0x7969, register 4 (advertisement) 0x01E1, register 16 (specific control) 0x0068, register 17 (specific status) 0x0000.
- R2: Registers 2, 5, 9 and 10 read 0x0141 (VENDOR_ID default), 0x01E0, 0x1E00 and 0x3C00. Register 3 reads the current value of `ext_id_i`.
- R3: Registers 6, 7, 8, 15, 18, 19, 20, 21, 26, 29 and 30 read 0x0000. A write to any of them changes no readable value.
- R4: Register numbers 11–14, 22–25, 27, 28 and 31 read 0x0000. A write to any of them changes no readable value.
- R5: A write to register 1, 2, 3, 5, 9, 10 or 17 is discarded, and a later read returns the value it had before the write.
- R6: A write to register 4 or 16 is stored in full, and a later read returns the written value.
- R7: A write to register 0 with bit 15 set is not stored. A write to register 0 with bit 15 clear is stored as given.
- R8: A read of register 1 returns the latched value, in which bit 2 is the link bit. On the same edge, that bit is reloaded from the live link bit.
- R9: The live link bit is bit 10 of register 17 and follows `link_up_i` one clock later. When `link_up_i` is low, the live bit and the latched bit both clear on the same edge. A rising link sets only the live bit.
- R10: `rd_data_o` is valid one clock after `rd_en_i`. It keeps that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| addr_i | input | 5 | Register number |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |
| link_up_i | input | 1 | Current link state |
| ext_id_i | input | 16 | Extended identifier value for register 3 |

## Verification
The bench builds the block with the default parameters: a 5-bit address, 16-bit data and the default vendor identifier. With these settings, a sweep over all 32 register numbers reaches every register, including every absent one. The bench also sequences link changes around status reads. This exposes the latched-low behaviour: a stale zero stays until it is read, and a drop that lands between two reads is still seen.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;
  localparam int REG_W = 16;

  // register numbers the logic depends on
  localparam int A_CTRL    = 0;
  localparam int A_STAT    = 1;
  localparam int A_ID_HI   = 2;
  localparam int A_ID_LO   = 3;
  localparam int A_ADV     = 4;
  localparam int A_PARTNER = 5;
  localparam int A_GIG_CTL = 9;
  localparam int A_GIG_ST  = 10;
  localparam int A_SP_CTL  = 16;
  localparam int A_SP_ST   = 17;

  // fixed read values
  localparam logic [REG_W-1:0] STAT_BASE    = 16'h7969;
  localparam logic [REG_W-1:0] PARTNER_VAL  = 16'h01E0;
  localparam logic [REG_W-1:0] GIG_CTL_VAL  = 16'h1E00;
  localparam logic [REG_W-1:0] GIG_ST_VAL   = 16'h3C00;

  localparam int STAT_LINK_BIT = 2;
  localparam int SP_LINK_BIT   = 10;
  localparam int CTRL_RST_BIT  = 15;

  // writable storage bank
  localparam int NUM_RW = 3;
  localparam int RW_CTRL_IDX = 0;
  localparam int RW_ADDR [NUM_RW] = '{A_CTRL, A_ADV, A_SP_CTL};
  localparam logic [REG_W-1:0] RW_INIT [NUM_RW] = '{16'h1140, 16'h01E1, 16'h0068};

  typedef struct packed {
    logic present;
    logic rd_ok;
    logic wr_ok;
  } acc_t;
endpackage

// File: rtl/phymgmt_decode.sv
module phymgmt_decode
  import phymgmt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  always_comb begin
    acc_o = '0;
    case (int'(addr_i))
      0, 4, 16:                         acc_o = '{present: 1'b1, rd_ok: 1'b1, wr_ok: 1'b1};
      1, 2, 3, 5, 9, 10, 17:            acc_o = '{present: 1'b1, rd_ok: 1'b1, wr_ok: 1'b0};
      6, 7, 8, 15, 18, 19, 20, 21, 26,
      29, 30:                           acc_o = '{present: 1'b1, rd_ok: 1'b0, wr_ok: 1'b0};
      default:                          acc_o = '0;
    endcase
  end
endmodule

// File: rtl/phymgmt_rw_bank.sv
module phymgmt_rw_bank
  import phymgmt_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int NUM    = NUM_RW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM-1:0]             wr_sel_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM-1:0][DATA_W-1:0] q_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q_o[i] <= DATA_W'(RW_INIT[i]);
      else if (wr_sel_i[i]) q_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/phymgmt_link_track.sv
module phymgmt_link_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_up_i,
  input  logic stat_rd_i,
  output logic live_o,
  output logic latched_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_o    <= 1'b0;
      latched_o <= 1'b0;
    end else begin
      live_o <= link_up_i;
      if (!link_up_i)     latched_o <= 1'b0;
      else if (stat_rd_i) latched_o <= live_o;
    end
  end
endmodule

// File: rtl/phymgmt_regs.sv
module phymgmt_regs
  import phymgmt_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter int              DATA_W    = REG_W,
  parameter logic [15:0]     VENDOR_ID = 16'h0141
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              link_up_i,
  input  logic [DATA_W-1:0] ext_id_i
);
  acc_t                       acc;
  logic [NUM_RW-1:0]          wr_sel;
  logic [NUM_RW-1:0][DATA_W-1:0] rw_q;
  logic                       live, latched;
  logic                       stat_rd;
  logic [DATA_W-1:0]          rd_val;
  logic [DATA_W-1:0]          ctrl_val;

  phymgmt_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .acc_o(acc));

  for (genvar i = 0; i < NUM_RW; i++) begin : g_sel
    logic veto;
    if (i == RW_CTRL_IDX) begin : g_ctrl
      assign veto = wr_data_i[CTRL_RST_BIT];
    end else begin : g_plain
      assign veto = 1'b0;
    end
    assign wr_sel[i] = wr_en_i && acc.wr_ok && (int'(addr_i) == RW_ADDR[i]) && !veto;
  end

  phymgmt_rw_bank #(.DATA_W(DATA_W), .NUM(NUM_RW)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_sel_i(wr_sel), .wr_data_i(wr_data_i), .q_o(rw_q)
  );

  assign stat_rd  = rd_en_i && (int'(addr_i) == A_STAT);
  assign ctrl_val = rw_q[RW_CTRL_IDX];

  phymgmt_link_track u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .link_up_i(link_up_i),
    .stat_rd_i(stat_rd), .live_o(live), .latched_o(latched)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (int'(addr_i) == RW_ADDR[i]) rd_val = rw_q[i];
    case (int'(addr_i))
      A_STAT:    begin
                   rd_val = DATA_W'(STAT_BASE);
                   rd_val[STAT_LINK_BIT] = latched;
                 end
      A_ID_HI:   rd_val = DATA_W'(VENDOR_ID);
      A_ID_LO:   rd_val = ext_id_i;
      A_PARTNER: rd_val = DATA_W'(PARTNER_VAL);
      A_GIG_CTL: rd_val = DATA_W'(GIG_CTL_VAL);
      A_GIG_ST:  rd_val = DATA_W'(GIG_ST_VAL);
      A_SP_ST:   begin
                   rd_val = '0;
                   rd_val[SP_LINK_BIT] = live;
                 end
      default:   ;
    endcase
    if (!acc.rd_ok) rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_val;
  end
endmodule

// File: rtl/phymgmt_regs_chk.sv
module phymgmt_regs_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              link_up_i,
  input logic              live,
  input logic              latched,
  input logic [DATA_W-1:0] ctrl_val
);
  logic absent;
  assign absent = (addr_i >= 11 && addr_i <= 14) || (addr_i >= 22 && addr_i <= 25) ||
                  addr_i == 27 || addr_i == 28 || addr_i == 31;

  p_absent_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && absent |=> rd_data_o == '0);

  p_gig_status_const_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == 10 |=> rd_data_o == 16'h3C00);

  p_ctrl_reset_bit_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 0 && wr_data_i[15] |=> $stable(ctrl_val));

  p_link_down_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |=> !live && !latched);

  p_latch_sets_on_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched) |-> $past(rd_en_i && addr_i == 1));

  p_rdata_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind phymgmt_regs phymgmt_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .link_up_i(link_up_i), .live(live), .latched(latched), .ctrl_val(ctrl_val)
);

// File: tb/phymgmt_regs_bench.sv
module phymgmt_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, link_up = 1'b0;
  logic [15:0] wdata = '0, ext_id = 16'h0C55;
  logic [15:0] rdata;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  phymgmt_regs u_phymgmt_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata), .link_up_i(link_up), .ext_id_i(ext_id)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset_values;
    logic [15:0] v;
    rd(0, v);  check("R1 ctrl", v, 16'h1140);
    rd(1, v);  check("R1 status", v, 16'h7969);
    rd(4, v);  check("R1 adv", v, 16'h01E1);
    rd(16, v); check("R1 spctl", v, 16'h0068);
    rd(17, v); check("R1 spstat", v, 16'h0000);
  endtask

  task automatic t_fixed_values;
    logic [15:0] v;
    rd(2, v);  check("R2 id hi", v, 16'h0141);
    rd(3, v);  check("R2 id lo", v, 16'h0C55);
    ext_id = 16'hA5A5;
    rd(3, v);  check("R2 id lo live", v, 16'hA5A5);
    rd(5, v);  check("R2 partner", v, 16'h01E0);
    rd(9, v);  check("R2 gig ctl", v, 16'h1E00);
    rd(10, v); check("R2 gig st", v, 16'h3C00);
  endtask

  task automatic t_zero_regs;
    logic [15:0] v;
    int unimp [11] = '{6, 7, 8, 15, 18, 19, 20, 21, 26, 29, 30};
    int absent [11] = '{11, 12, 13, 14, 22, 23, 24, 25, 27, 28, 31};
    foreach (unimp[i]) begin
      wr(5'(unimp[i]), 16'hFFFF);
      rd(5'(unimp[i]), v); check("R3 unimpl read", v, 16'h0000);
    end
    foreach (absent[i]) begin
      wr(5'(absent[i]), 16'hFFFF);
      rd(5'(absent[i]), v); check("R4 absent read", v, 16'h0000);
    end
    // R3 R4: nothing stored elsewhere
    rd(4, v);  check("R4 adv untouched", v, 16'h01E1);
    rd(16, v); check("R3 spctl untouched", v, 16'h0068);
    rd(0, v);  check("R3 ctrl untouched", v, 16'h1140);
  endtask

  task automatic t_readonly;
    logic [15:0] v;
    int ro [7] = '{1, 2, 3, 5, 9, 10, 17};
    foreach (ro[i]) wr(5'(ro[i]), 16'h5AA5);
    rd(1, v);  check("R5 status", v, 16'h7969);
    rd(2, v);  check("R5 id hi", v, 16'h0141);
    rd(3, v);  check("R5 id lo", v, 16'hA5A5);
    rd(5, v);  check("R5 partner", v, 16'h01E0);
    rd(9, v);  check("R5 gig ctl", v, 16'h1E00);
    rd(10, v); check("R5 gig st", v, 16'h3C00);
    rd(17, v); check("R5 spstat", v, 16'h0000);
  endtask

  task automatic t_readwrite;
    logic [15:0] v;
    wr(4, 16'hBEEF);  rd(4, v);  check("R6 adv", v, 16'hBEEF);
    wr(16, 16'h1234); rd(16, v); check("R6 spctl", v, 16'h1234);
    wr(4, 16'h0000);  rd(4, v);  check("R6 adv zero", v, 16'h0000);
  endtask

  task automatic t_ctrl;
    logic [15:0] v;
    wr(0, 16'h8000);  rd(0, v); check("R7 reset bit blocked", v, 16'h1140);
    wr(0, 16'h7FFF);  rd(0, v); check("R7 stored", v, 16'h7FFF);
    wr(0, 16'hC123);  rd(0, v); check("R7 reset bit blocked 2", v, 16'h7FFF);
    wr(0, 16'h0100);  rd(0, v); check("R7 stored 2", v, 16'h0100);
  endtask

  task automatic t_link;
    logic [15:0] v;
    @(negedge clk); link_up = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(17, v); check("R9 live up", v, 16'h0400);
    rd(1, v);  check("R8 stale latched", v, 16'h7969);
    rd(1, v);  check("R8 reloaded", v, 16'h796D);
    rd(1, v);  check("R8 stays up", v, 16'h796D);
    @(negedge clk); link_up = 1'b0;
    @(negedge clk); link_up = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(17, v); check("R9 live back up", v, 16'h0400);
    rd(1, v);  check("R9 drop latched", v, 16'h7969);
    rd(1, v);  check("R8 reloaded after drop", v, 16'h796D);
    @(negedge clk); link_up = 1'b0;
    @(negedge clk);
    rd(17, v); check("R9 live down", v, 16'h0000);
    rd(1, v);  check("R9 latched down", v, 16'h7969);
  endtask

  task automatic t_timing;
    logic [15:0] v;
    @(negedge clk); addr = 10; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; addr = 2;
    check("R10 valid after one clock", rdata, 16'h3C00);
    @(negedge clk); @(negedge clk);
    check("R10 held", rdata, 16'h3C00);
    wr(4, 16'h7777);
    check("R10 held over write", rdata, 16'h3C00);
    rd(2, v); check("R10 next read", v, 16'h0141);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset rdata", rdata, 16'h0000);
    rst_n = 1'b1;
    t_reset_values();
    t_fixed_values();
    t_zero_regs();
    t_readonly();
    t_readwrite();
    t_ctrl();
    t_link();
    t_timing();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule